// File: doc/BRIEF.md
# Password-Fed Watchdog Timer

This block guards a system against software that stops making progress. Once enabled, an internal counter climbs toward a 24-bit limit held in the control word. Software keeps the system alive by writing a fixed 32-bit key, 0x709D1AB3, to the feed word at byte offset 0x04, which restarts the count. If the count reaches the limit, the block raises a one-cycle reset request for the system reset generator. It then wipes its own configuration and records that the last reset came from the watchdog.

The control word can be frozen by its lock bit. Once set, the lock holds until a hardware reset or a watchdog trip clears it. In strict mode the block treats misuse as a fault: a wrong feed key, or a write to the frozen control word, causes an immediate trip. The debug-mode and sleep-mode inputs pause the count unless the matching permission bit is set.

A single state machine drives the behaviour. Its states are IDLE (disabled, count at zero), RUN (counting), HOLD (paused by a debug or sleep input) and FIRE (the one cycle in which the reset request is high). Its transitions are named as follows:
- ARM goes from IDLE to RUN when enabled.
- SUSPEND goes from RUN to HOLD on a pause condition.
- RESUME goes from HOLD to RUN when the pause condition ends.
- DISARM goes from RUN or HOLD to IDLE when disabled.
- EXPIRE goes from RUN to FIRE when the limit is reached.
- BREACH goes from any state except FIRE to FIRE on a strict-mode violation.
- RECOVER goes from FIRE to IDLE.

Top module: `wdog_guard`

## Requirements
- R1: The hardware reset (rst_ni low across at least one clock edge) leaves every control field at zero and wdt_rst_req_o low. The cause field in bits 6:5 reads 1 if rst_dbg_i was high during reset and 0 otherwise.
- R2: The control word is read and written at byte offset 0x00. Bit 0 is enable and bits 31:8 hold the limit T. With enable set and no feed or pause, wdt_rst_req_o goes high after the (T+2)th rising edge following the edge that stores the enabling write. This includes T = 0.
- R3: The reset request lasts exactly one cycle. On the next edge, enable, lock, bits 2, 3 and 4, and the limit all clear, and the cause field becomes 2.
- R4: A write of 0x709D1AB3 to byte offset 0x04 restarts the count from zero. The request then follows T+1 edges after the feed edge.
- R5: Outside strict mode, a write of any other value to offset 0x04 has no effect on timing or state.
- R6: While lock (bit 1) is set, writes to the control word are ignored. Only a hardware reset or a watchdog trip clears the lock.
- R7: With strict mode (bit 4) set, a wrong feed key or a control write while locked raises the request on the edge that takes the write. The cause field becomes 2 afterwards. This happens even with enable clear.
- R8: While dbg_mode_i is high and bit 2 is clear, the count is held. A pause seen on P edges delays the request by P+1 edges. With bit 2 set, the request is not delayed.
- R9: The sleep-mode input and bit 3 behave the same way as in R8.
- R10: Clearing enable stops the count, and no request follows. Enabling again starts the count from zero.
- R11: Reads at offset 0x04 or any other offset except 0x00 return zero. Bit 7 always reads zero, and writes cannot change the cause field.
- R12: Lowering the limit below the current count causes a trip on the next counting edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Hardware reset, active low |
| rst_dbg_i | input | 1 | High during reset if the debugger caused that reset |
| dbg_mode_i | input | 1 | Core is halted in debug mode |
| sleep_mode_i | input | 1 | Core is in sleep mode |
| bus_we_i | input | 1 | Register write strobe |
| bus_addr_i | input | 3 | Byte offset of the register access |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for bus_addr_i (combinational) |
| wdt_rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A control write changes the read-back value on the edge that takes it. The first counting edge follows one edge later, so an enable with limit T yields the request T+2 edges after the write edge. A feed yields it T+1 edges after, and a strict-mode breach on the same edge. The bench drives inputs and compares outputs at the falling edge against a behavioural model that advances on each rising edge. Each scenario also counts falling edges from the triggering write and checks that the request first appears at exactly the predicted count, including pause stretches of P+1 edges.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

    localparam int unsigned WD_DATA_W  = 32;
    localparam int unsigned WD_TMO_W   = 24;
    localparam logic [31:0] WD_FEED_KEY = 32'h709D_1AB3;

    // control word field positions (software-visible)
    localparam int unsigned WD_B_EN     = 0;
    localparam int unsigned WD_B_LOCK   = 1;
    localparam int unsigned WD_B_RUNDBG = 2;
    localparam int unsigned WD_B_RUNSLP = 3;
    localparam int unsigned WD_B_STRICT = 4;
    localparam int unsigned WD_B_CAUSE  = 5;
    localparam int unsigned WD_B_TMO    = WD_DATA_W - WD_TMO_W;

    // last-reset origin codes
    localparam logic [1:0] WD_CAUSE_EXT = 2'd0;
    localparam logic [1:0] WD_CAUSE_DBG = 2'd1;
    localparam logic [1:0] WD_CAUSE_WDT = 2'd2;

    typedef enum logic [1:0] {
        WD_IDLE = 2'd0,
        WD_RUN  = 2'd1,
        WD_HOLD = 2'd2,
        WD_FIRE = 2'd3
    } wd_state_e;

    typedef struct packed {
        logic [WD_TMO_W-1:0] tmo;
        logic                strict;
        logic                run_slp;
        logic                run_dbg;
        logic                lock;
        logic                en;
    } wd_cfg_t;

endpackage

// File: rtl/wdog_cfg_regs.sv
module wdog_cfg_regs
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W   = 3,
    parameter logic [31:0] FEED_KEY = WD_FEED_KEY
) (
    input  logic                 clk_i,
    input  logic                 rst_ni,
    input  logic                 we_i,
    input  logic [ADDR_W-1:0]    addr_i,
    input  logic [WD_DATA_W-1:0] wdata_i,
    input  logic                 fire_i,
    output wd_cfg_t              cfg_o,
    output logic                 feed_ok_o,
    output logic                 breach_o
);

    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);
    localparam logic [ADDR_W-1:0] OFS_FEED = ADDR_W'(4);

    wd_cfg_t cfg_q;
    logic    ctrl_hit;
    logic    feed_hit;
    logic    key_match;

    // bus writes are dropped in the cycle the request is out
    assign ctrl_hit  = we_i && (addr_i == OFS_CTRL) && !fire_i;
    assign feed_hit  = we_i && (addr_i == OFS_FEED) && !fire_i;
    assign key_match = (wdata_i == FEED_KEY);

    assign feed_ok_o = feed_hit && key_match;
    assign breach_o  = cfg_q.strict && ((ctrl_hit && cfg_q.lock) || (feed_hit && !key_match));

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cfg_q <= '0;
        end else if (fire_i) begin
            cfg_q <= '0;
        end else if (ctrl_hit && !cfg_q.lock) begin
            cfg_q.en      <= wdata_i[WD_B_EN];
            cfg_q.lock    <= wdata_i[WD_B_LOCK];
            cfg_q.run_dbg <= wdata_i[WD_B_RUNDBG];
            cfg_q.run_slp <= wdata_i[WD_B_RUNSLP];
            cfg_q.strict  <= wdata_i[WD_B_STRICT];
            cfg_q.tmo     <= wdata_i[WD_DATA_W-1:WD_B_TMO];
        end
    end

    assign cfg_o = cfg_q;

    AST_LOCK_FREEZES_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni) (cfg_q.lock && !fire_i) |=> $stable(cfg_q)); // R6
    AST_FIRE_WIPES_CFG: assert property (@(posedge clk_i) disable iff (!rst_ni) fire_i |=> (cfg_q == '0)); // R3

endmodule

// File: rtl/wdog_fsm.sv
module wdog_fsm
    import wdog_pkg::*;
#(
    parameter int unsigned TMO_W = WD_TMO_W
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             en_i,
    input  logic [TMO_W-1:0] tmo_i,
    input  logic             hold_i,
    input  logic             feed_ok_i,
    input  logic             breach_i,
    output wd_state_e        state_o,
    output logic             rst_req_o
);

    wd_state_e        state_q;
    wd_state_e        state_d;
    logic [TMO_W-1:0] cnt_q;
    logic             limit_hit;

    assign limit_hit = (cnt_q >= tmo_i);

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= WD_IDLE;
        else         state_q <= state_d;
    end

    // transitions: ARM, SUSPEND, RESUME, DISARM, EXPIRE, BREACH, RECOVER
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            WD_IDLE: begin
                if (breach_i)  state_d = WD_FIRE;
                else if (en_i) state_d = WD_RUN;
            end
            WD_RUN: begin
                if (breach_i)                     state_d = WD_FIRE;
                else if (!en_i)                   state_d = WD_IDLE;
                else if (hold_i)                  state_d = WD_HOLD;
                else if (limit_hit && !feed_ok_i) state_d = WD_FIRE;
            end
            WD_HOLD: begin
                if (breach_i)     state_d = WD_FIRE;
                else if (!en_i)   state_d = WD_IDLE;
                else if (!hold_i) state_d = WD_RUN;
            end
            WD_FIRE: state_d = WD_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        rst_req_o = 1'b0;
        unique case (state_q)
            WD_FIRE: rst_req_o = 1'b1;
            WD_IDLE, WD_RUN, WD_HOLD: rst_req_o = 1'b0;
        endcase
    end

    // elapsed-time counter
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if ((state_q == WD_FIRE) || (state_d == WD_IDLE) || feed_ok_i) begin
            cnt_q <= '0;
        end else if ((state_q == WD_RUN) && (state_d == WD_RUN)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign state_o = state_q;

    AST_PULSE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni) rst_req_o |=> !rst_req_o); // R3
    AST_HOLD_FREEZES_CNT: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_q == WD_HOLD && en_i && !breach_i && !feed_ok_i) |=> $stable(cnt_q)); // R8
    AST_FEED_AVERTS_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni) (feed_ok_i && !breach_i && state_q != WD_FIRE) |=> !rst_req_o); // R4
    AST_IDLE_CNT_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni) (state_q == WD_IDLE) |-> (cnt_q == '0)); // R10

endmodule

// File: rtl/wdog_cause.sv
module wdog_cause
    import wdog_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       rst_dbg_i,
    input  logic       fire_i,
    output logic [1:0] cause_o
);

    logic [1:0] cause_q;

    // captured synchronously so the origin input is sampled while reset is held
    always_ff @(posedge clk_i) begin
        if (!rst_ni)     cause_q <= rst_dbg_i ? WD_CAUSE_DBG : WD_CAUSE_EXT;
        else if (fire_i) cause_q <= WD_CAUSE_WDT;
    end

    assign cause_o = cause_q;

    AST_CAUSE_AFTER_FIRE: assert property (@(posedge clk_i) disable iff (!rst_ni) fire_i |=> (cause_q == WD_CAUSE_WDT)); // R3
    AST_CAUSE_STEADY: assert property (@(posedge clk_i) disable iff (!rst_ni) (!fire_i && $past(rst_ni)) |=> $stable(cause_q)); // R11

endmodule

// File: rtl/wdog_guard.sv
module wdog_guard
    import wdog_pkg::*;
#(
    parameter int unsigned ADDR_W   = 3,
    parameter logic [31:0] FEED_KEY = WD_FEED_KEY
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              rst_dbg_i,
    input  logic              dbg_mode_i,
    input  logic              sleep_mode_i,
    input  logic              bus_we_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              wdt_rst_req_o
);

    localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'(0);

    wd_cfg_t    cfg;
    wd_state_e  state;
    logic       feed_ok;
    logic       breach;
    logic       fire;
    logic       hold_req;
    logic       req;
    logic [1:0] cause;

    assign fire     = (state == WD_FIRE);
    assign hold_req = (dbg_mode_i && !cfg.run_dbg) || (sleep_mode_i && !cfg.run_slp);

    wdog_cfg_regs #(
        .ADDR_W   (ADDR_W),
        .FEED_KEY (FEED_KEY)
    ) u_regs (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .we_i      (bus_we_i),
        .addr_i    (bus_addr_i),
        .wdata_i   (bus_wdata_i),
        .fire_i    (fire),
        .cfg_o     (cfg),
        .feed_ok_o (feed_ok),
        .breach_o  (breach)
    );

    wdog_fsm #(
        .TMO_W (WD_TMO_W)
    ) u_fsm (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .en_i      (cfg.en),
        .tmo_i     (cfg.tmo),
        .hold_i    (hold_req),
        .feed_ok_i (feed_ok),
        .breach_i  (breach),
        .state_o   (state),
        .rst_req_o (req)
    );

    wdog_cause u_cause (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .rst_dbg_i (rst_dbg_i),
        .fire_i    (fire),
        .cause_o   (cause)
    );

    always_comb begin
        bus_rdata_o = '0;
        if (bus_addr_i == OFS_CTRL) begin
            bus_rdata_o = {cfg.tmo, 1'b0, cause, cfg.strict, cfg.run_slp,
                           cfg.run_dbg, cfg.lock, cfg.en};
        end
    end

    assign wdt_rst_req_o = req;

    AST_BREACH_FIRES_NOW: assert property (@(posedge clk_i) disable iff (!rst_ni) breach |=> wdt_rst_req_o); // R7
    AST_OFF_NO_EXPIRE: assert property (@(posedge clk_i) disable iff (!rst_ni) (!cfg.en && !breach) |=> !wdt_rst_req_o); // R10

endmodule

// File: tb/test_wdog_guard.sv
`timescale 1ns/1ps
module test_wdog_guard;

    localparam logic [31:0] KEY = 32'h709D_1AB3;
    localparam logic [31:0] BAD = 32'h1234_5678;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rst_dbg = 1'b0;
    logic        dbg = 1'b0;
    logic        slp = 1'b0;
    logic        we = 1'b0;
    logic [2:0]  addr = 3'd0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        req;

    always #2.5 clk = ~clk;

    wdog_guard i_wdog_guard (
        .clk_i         (clk),
        .rst_ni        (rst_n),
        .rst_dbg_i     (rst_dbg),
        .dbg_mode_i    (dbg),
        .sleep_mode_i  (slp),
        .bus_we_i      (we),
        .bus_addr_i    (addr),
        .bus_wdata_i   (wdata),
        .bus_rdata_o   (rdata),
        .wdt_rst_req_o (req)
    );

    int    n_chk = 0;
    int    n_bad = 0;
    string tag = "R1";

    // behavioural reference: 0 off, 1 counting, 2 paused, 3 requesting
    int          m_st = 0;
    longint      m_cnt = 0;
    longint      m_tmo = 0;
    bit          m_en, m_lock, m_rdbg, m_rslp, m_strict;
    int          m_cause = 0;

    always @(posedge clk) begin
        bit cw, fw, good, viol, hold;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_tmo = 0;
            m_en = 0; m_lock = 0; m_rdbg = 0; m_rslp = 0; m_strict = 0;
            m_cause = rst_dbg ? 1 : 0;
        end else if (m_st == 3) begin
            m_st = 0; m_cnt = 0; m_tmo = 0;
            m_en = 0; m_lock = 0; m_rdbg = 0; m_rslp = 0; m_strict = 0;
            m_cause = 2;
        end else begin
            cw   = we && (addr == 3'd0);
            fw   = we && (addr == 3'd4);
            good = fw && (wdata == KEY);
            viol = m_strict && ((cw && m_lock) || (fw && (wdata != KEY)));
            hold = (dbg && !m_rdbg) || (slp && !m_rslp);
            if (viol) begin
                m_st = 3;
            end else begin
                if (m_st == 0) begin
                    if (m_en) m_st = 1;
                end else if (m_st == 1) begin
                    if (!m_en) begin m_st = 0; m_cnt = 0; end
                    else if (hold) m_st = 2;
                    else if (good) m_cnt = 0;
                    else if (m_cnt >= m_tmo) m_st = 3;
                    else m_cnt = m_cnt + 1;
                end else begin
                    if (!m_en) begin m_st = 0; m_cnt = 0; end
                    else if (!hold) m_st = 1;
                end
                if (good) m_cnt = 0;
                if (cw && !m_lock) begin
                    m_en = wdata[0]; m_lock = wdata[1]; m_rdbg = wdata[2];
                    m_rslp = wdata[3]; m_strict = wdata[4];
                    m_tmo = longint'(wdata[31:8]);
                end
            end
        end
    end

    function automatic logic [31:0] exp_rdata();
        logic [31:0] v;
        v = '0;
        if (addr == 3'd0) begin
            v[0] = m_en; v[1] = m_lock; v[2] = m_rdbg; v[3] = m_rslp; v[4] = m_strict;
            v[6:5] = m_cause[1:0];
            v[31:8] = m_tmo[23:0];
        end
        return v;
    endfunction

    function automatic logic [31:0] mk(bit en, bit lk, bit rd, bit rs, bit st, int tmo);
        logic [23:0] t;
        t = tmo[23:0];
        return {t, 3'b000, st, rs, rd, lk, en};
    endfunction

    task automatic check(string rq, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    // one cycle: compare at the falling edge, then drive for the next rising edge
    task automatic step(bit w, logic [2:0] a, logic [31:0] d);
        @(negedge clk);
        if (rst_n) begin
            check(tag, rdata, exp_rdata(), "rdata vs model");
            check(tag, {31'd0, req}, {31'd0, (m_st == 3)}, "request vs model");
        end
        we = w; addr = a; wdata = d;
    endtask

    task automatic do_reset(bit from_dbg);
        @(negedge clk);
        rst_n = 1'b0; rst_dbg = from_dbg; we = 0; addr = 0; wdata = 0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1; rst_dbg = 1'b0;
    endtask

    // counts cycles after the triggering write until the request is seen
    task automatic run_trip(int limit, int w_at, logic [2:0] w_a, logic [31:0] w_d,
                            int p_lo, int p_hi, bit use_dbg, output int n);
        n = -1;
        for (int i = 1; i <= limit; i++) begin
            dbg = use_dbg && (i >= p_lo) && (i <= p_hi);
            slp = !use_dbg && (i >= p_lo) && (i <= p_hi);
            if (i == w_at) step(1'b1, w_a, w_d);
            else           step(1'b0, 3'd0, 32'd0);
            if (req === 1'b1) begin
                n = i;
                break;
            end
        end
        dbg = 1'b0; slp = 1'b0;
    endtask

    task automatic settle();
        repeat (3) step(1'b0, 3'd0, 32'd0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

    initial begin
        int n;

        // R1: reset state, both origins
        tag = "R1";
        do_reset(1'b0);
        step(0, 3'd0, 0);
        check("R1", rdata, 32'h0, "ctrl after external reset");
        check("R1", {31'd0, req}, 32'd0, "request after reset");
        do_reset(1'b1);
        step(0, 3'd0, 0);
        check("R1", rdata, 32'h20, "ctrl after debugger reset");
        do_reset(1'b0);

        // R2 / R3: plain expiry
        tag = "R2";
        step(1, 3'd0, mk(1, 0, 0, 0, 0, 10));
        run_trip(60, 0, 0, 0, 0, -1, 1, n);
        check("R2", n, 13, "cycles to request, T=10");
        tag = "R3";
        step(0, 3'd0, 0);
        check("R3", {31'd0, req}, 32'd0, "request one cycle only");
        settle();
        check("R3", rdata, 32'h40, "ctrl cleared, cause watchdog");

        tag = "R2";
        step(1, 3'd0, mk(1, 0, 0, 0, 0, 0));
        run_trip(20, 0, 0, 0, 0, -1, 1, n);
        check("R2", n, 3, "cycles to request, T=0");
        settle();

        // R4: correct feed restarts count
        tag = "R4";
        step(1, 3'd0, mk(1, 0, 0, 0, 0, 20));
        run_trip(80, 8, 3'd4, KEY, 0, -1, 1, n);
        check("R4", n, 30, "request after feed at step 8");
        settle();

        // R5: wrong key ignored outside strict mode
        tag = "R5";
        step(1, 3'd0, mk(1, 0, 0, 0, 0, 20));
        run_trip(80, 5, 3'd4, BAD, 0, -1, 1, n);
        check("R5", n, 23, "wrong key leaves timing alone");
        settle();

        // R6: lock blocks control writes, trip clears lock
        tag = "R6";
        step(1, 3'd0, mk(1, 1, 0, 0, 0, 15));
        run_trip(80, 2, 3'd0, mk(0, 0, 0, 0, 0, 0), 0, -1, 1, n);
        check("R6", n, 18, "locked disable ignored");
        settle();
        check("R6", rdata & 32'h2, 32'h0, "lock cleared by trip");

        // R7: strict violations
        tag = "R7";
        step(1, 3'd0, mk(1, 0, 0, 0, 1, 200));
        run_trip(40, 3, 3'd4, BAD, 0, -1, 1, n);
        check("R7", n, 4, "strict wrong key trips at once");
        settle();
        check("R7", rdata, 32'h40, "cause after strict key trip");
        step(1, 3'd0, mk(0, 1, 0, 0, 1, 0));
        run_trip(40, 1, 3'd0, mk(1, 0, 0, 0, 0, 9), 0, -1, 1, n);
        check("R7", n, 2, "strict locked write trips while disabled");
        settle();

        // R8: debug pause
        tag = "R8";
        step(1, 3'd0, mk(1, 0, 0, 0, 0, 10));
        run_trip(80, 0, 0, 0, 3, 10, 1, n);
        check("R8", n, 22, "debug pause of 8 edges");
        settle();
        step(1, 3'd0, mk(1, 0, 1, 0, 0, 10));
        run_trip(80, 0, 0, 0, 3, 10, 1, n);
        check("R8", n, 13, "debug permitted, no delay");
        settle();

        // R9: sleep pause
        tag = "R9";
        step(1, 3'd0, mk(1, 0, 0, 0, 0, 10));
        run_trip(80, 0, 0, 0, 3, 10, 0, n);
        check("R9", n, 22, "sleep pause of 8 edges");
        settle();
        step(1, 3'd0, mk(1, 0, 0, 1, 0, 10));
        run_trip(80, 0, 0, 0, 3, 10, 0, n);
        check("R9", n, 13, "sleep permitted, no delay");
        settle();

        // R10: disable stops, re-enable restarts from zero
        tag = "R10";
        step(1, 3'd0, mk(1, 0, 0, 0, 0, 10));
        run_trip(60, 4, 3'd0, mk(0, 0, 0, 0, 0, 10), 0, -1, 1, n);
        check("R10", n, -1, "no request once disabled");
        step(1, 3'd0, mk(1, 0, 0, 0, 0, 10));
        run_trip(60, 0, 0, 0, 0, -1, 1, n);
        check("R10", n, 13, "re-enable counts from zero");
        settle();

        // R11: read map and read-only bits
        tag = "R11";
        step(1, 3'd0, mk(1, 0, 0, 0, 0, 500) | 32'hE0);
        step(0, 3'd4, 0);
        #1 check("R11", rdata, 32'h0, "feed offset reads zero");
        step(0, 3'd6, 0);
        #1 check("R11", rdata, 32'h0, "unused offset reads zero");
        step(0, 3'd0, 0);
        #1 check("R11", rdata, mk(1, 0, 0, 0, 0, 500) | 32'h40, "bit7 zero, cause kept");
        step(1, 3'd0, 32'h0);
        settle();

        // R12: lowering the limit below the count
        tag = "R12";
        step(1, 3'd0, mk(1, 0, 0, 0, 0, 100));
        run_trip(80, 20, 3'd0, mk(1, 0, 0, 0, 0, 5), 0, -1, 1, n);
        check("R12", n, 22, "trip right after limit lowered");
        settle();

        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end

endmodule